// File: doc/BRIEF.md
# Synchronous Half-Bridge Gate Sequencer

This block drives the two switches of a synchronous buck power stage from a pulse-width command. Two comparator flags report whether the command pin sits above the high threshold or below the low threshold. When it is high, the block turns the low-side switch off and then turns the high-side switch on. When it is low, it does the reverse. Both switches stay off for a dead interval between these two steps, so they never conduct together.

The length of the dead interval is a register counted in clock cycles. After each completed interval it moves one step. It gets shorter when the low-side body diode was seen conducting during the interval, and longer when the diode was not seen. The value is clamped between a lower and an upper bound.

Three further conditions can hold the stage off. A command pin that stays at mid level longer than a qualification delay is treated as floating, and both switches park off until the pin has been valid for the same delay. The high-side switch is allowed on only while a bootstrap-supply qualifier, which has hysteresis, is set. A global enable forces both switches off when it is low.

Top module: `hb_gate_sequencer`

## Requirements
- R1: The command level is encoded as follows: `pwm_hi`=1 with `pwm_lo`=0 means high, and `pwm_hi`=0 with `pwm_lo`=1 means low. Any other combination is mid. While the stage is enabled and not parked, a high level ends with only `gate_hs` on (when the bootstrap qualifier is set), and a low level ends with only `gate_ls` on.
- R2: `gate_hs` and `gate_ls` are never 1 in the same cycle. Each turn-on is preceded by exactly D consecutive cycles with both gates off, where D is the current dead-time value.
- R3: The dead-time value resets to DT_INIT. At the end of each completed dead interval, the value drops by 1 if `diode_sense` was 1 in any cycle of that interval, and otherwise rises by 1. The result is clamped to the range DT_MIN to DT_MAX. The first turn-on after reset also counts as a completed interval.
- R4: When the command is mid for TRI_DLY consecutive sampled cycles, `tri_active` rises on the TRI_DLY-th sampling edge, and both gates are off from the next edge. A mid run shorter than that is ignored: the gates keep the last valid level and the qualification count restarts.
- R5: While `tri_active` is 1, it clears only after TRI_DLY consecutive valid (high or low) samples. A shorter valid run leaves it set and restarts the count. `tri_active` does not depend on `enable`.
- R6: The bootstrap qualifier sets when `boot_hi`=1 and clears when `boot_lo`=1, with clear winning if both are 1. It holds its value while both are 0. While the qualifier is clear, `gate_hs` stays 0 and a high command leaves both gates off.
- R7: When `enable` is 0, both gates are 0 from the next clock edge.
- R8: During reset, `gate_hs`, `gate_ls` and `tri_active` are 0. The bootstrap qualifier is clear and the last valid level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global enable; 0 forces both switches off |
| pwm_hi | input | 1 | Command pin above high threshold |
| pwm_lo | input | 1 | Command pin below low threshold |
| boot_hi | input | 1 | Bootstrap supply above upper threshold |
| boot_lo | input | 1 | Bootstrap supply below lower threshold |
| diode_sense | input | 1 | Low-side body-diode conduction detected |
| gate_hs | output | 1 | High-side switch enable (registered) |
| gate_ls | output | 1 | Low-side switch enable (registered) |
| tri_active | output | 1 | Floating-input park indication (registered) |

## Verification
The bench builds the block with TRI_DLY=8, DT_MIN=2, DT_MAX=7 and DT_INIT=4. With these values, a run of dead-time measurements reaches both clamp bounds within a few transitions, and each gap can be checked cycle by cycle against a dead-time model kept in the bench. The short qualification delay makes it practical to probe mid runs of exactly TRI_DLY-1 and TRI_DLY cycles, which shows both the restart of the shared count and the exact cycles on which the block enters and leaves the parked state.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

  typedef enum logic [1:0] {
    SW_NONE = 2'b00,
    SW_LOW  = 2'b01,
    SW_HIGH = 2'b10
  } sw_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DEAD = 2'b01,
    ST_LS   = 2'b10,
    ST_HS   = 2'b11
  } gate_st_e;

  // Step the dead time after a completed interval, clamped to [lo, hi].
  function automatic logic [31:0] dead_next(input logic [31:0] cur,
                                            input logic conducted,
                                            input logic [31:0] lo,
                                            input logic [31:0] hi);
    logic [31:0] r;
    if (conducted) r = (cur > lo) ? cur - 32'd1 : lo;
    else           r = (cur < hi) ? cur + 32'd1 : hi;
    return r;
  endfunction

  // Which switch the stage should settle on.
  function automatic sw_sel_e pick_switch(input logic en, input logic park,
                                          input logic lvl_hi, input logic boot_ok);
    sw_sel_e s;
    if (!en || park)  s = SW_NONE;
    else if (!lvl_hi) s = SW_LOW;
    else if (boot_ok) s = SW_HIGH;
    else              s = SW_NONE;
    return s;
  endfunction

endpackage

// File: rtl/hb_level_qual.sv
module hb_level_qual #(
  parameter int TRI_DLY = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_hi,
  input  logic pwm_lo,
  output logic lvl_hi,
  output logic tri_active,
  output logic mid_now
);
  localparam int TW = $clog2(TRI_DLY + 1);
  localparam logic [TW-1:0] LAST = TW'(TRI_DLY - 1);

  logic [TW-1:0] qual_cnt;
  logic          qualifying;

  assign mid_now    = (pwm_hi == pwm_lo);
  // one shared counter: counts mid while active==0, valid while active==1
  assign qualifying = tri_active ? !mid_now : mid_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual_cnt   <= '0;
      tri_active <= 1'b0;
      lvl_hi     <= 1'b0;
    end else begin
      if (!mid_now) lvl_hi <= pwm_hi;
      if (!qualifying) begin
        qual_cnt <= '0;
      end else if (qual_cnt == LAST) begin
        qual_cnt   <= '0;
        tri_active <= !tri_active;
      end else begin
        qual_cnt <= qual_cnt + TW'(1);
      end
    end
  end

  a_r4_enter_on_mid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tri_active) |-> $past(mid_now));
  a_r5_exit_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tri_active) |-> !$past(mid_now));
  a_r4_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mid_now) |-> $stable(lvl_hi));
endmodule

// File: rtl/hb_boot_hyst.sv
module hb_boot_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_hi,
  input  logic boot_lo,
  output logic boot_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n)       boot_ok <= 1'b0;
    else if (boot_lo) boot_ok <= 1'b0;
    else if (boot_hi) boot_ok <= 1'b1;
  end

  a_r6_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    boot_lo |=> !boot_ok);
  a_r6_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_hi && !boot_lo) |=> $stable(boot_ok));
endmodule

// File: rtl/hb_dead_adapt.sv
module hb_dead_adapt #(
  parameter int DT_MIN  = 2,
  parameter int DT_MAX  = 31,
  parameter int DT_INIT = 8,
  parameter int DT_W    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_dead,
  input  logic            finish,
  input  logic            diode_sense,
  output logic [DT_W-1:0] dead_len
);
  import hb_seq_pkg::*;

  logic seen;
  logic conducted;

  assign conducted = seen | diode_sense;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dead_len <= DT_W'(DT_INIT);
      seen     <= 1'b0;
    end else begin
      if (!in_dead || finish) seen <= 1'b0;
      else                    seen <= conducted;
      if (finish)
        dead_len <= DT_W'(dead_next(32'(dead_len), conducted, 32'(DT_MIN), 32'(DT_MAX)));
    end
  end

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_len >= DT_W'(DT_MIN)) && (dead_len <= DT_W'(DT_MAX)));
  a_r3_moves_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dead_len) |-> $past(finish));
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dead_len) |-> (dead_len == $past(dead_len) + DT_W'(1)) ||
                           (dead_len == $past(dead_len) - DT_W'(1)));
endmodule

// File: rtl/hb_gate_fsm.sv
module hb_gate_fsm #(
  parameter int DT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  hb_seq_pkg::sw_sel_e want,
  input  logic [DT_W-1:0]     dead_len,
  output logic                gate_hs,
  output logic                gate_ls,
  output logic                in_dead,
  output logic                finish
);
  import hb_seq_pkg::*;

  gate_st_e        st, st_nxt;
  logic [DT_W-1:0] cnt, cnt_nxt;

  assign in_dead = (st == ST_DEAD);
  assign finish  = in_dead && (want != SW_NONE) && (cnt == '0);

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    unique case (st)
      ST_IDLE: if (want != SW_NONE) begin
        st_nxt  = ST_DEAD;
        cnt_nxt = dead_len - DT_W'(1);
      end
      ST_DEAD: begin
        if (want == SW_NONE)  st_nxt = ST_IDLE;
        else if (cnt == '0)   st_nxt = (want == SW_HIGH) ? ST_HS : ST_LS;
        else                  cnt_nxt = cnt - DT_W'(1);
      end
      ST_LS: if (want != SW_LOW) begin
        st_nxt  = (want == SW_NONE) ? ST_IDLE : ST_DEAD;
        cnt_nxt = dead_len - DT_W'(1);
      end
      ST_HS: if (want != SW_HIGH) begin
        st_nxt  = (want == SW_NONE) ? ST_IDLE : ST_DEAD;
        cnt_nxt = dead_len - DT_W'(1);
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      gate_hs <= 1'b0;
      gate_ls <= 1'b0;
    end else begin
      st      <= st_nxt;
      cnt     <= cnt_nxt;
      gate_hs <= (st_nxt == ST_HS);
      gate_ls <= (st_nxt == ST_LS);
    end
  end

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs && gate_ls));
  a_r2_hs_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hs) |-> $past(!gate_ls && !gate_hs));
  a_r2_ls_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_ls) |-> $past(!gate_ls && !gate_hs));
endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer #(
  parameter int TRI_DLY = 50,
  parameter int DT_MIN  = 2,
  parameter int DT_MAX  = 31,
  parameter int DT_INIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pwm_hi,
  input  logic pwm_lo,
  input  logic boot_hi,
  input  logic boot_lo,
  input  logic diode_sense,
  output logic gate_hs,
  output logic gate_ls,
  output logic tri_active
);
  import hb_seq_pkg::*;

  localparam int DT_W = $clog2(DT_MAX + 1);

  logic            lvl_hi, mid_now, boot_ok, in_dead, finish;
  logic [DT_W-1:0] dead_len;
  sw_sel_e         want;

  hb_level_qual #(.TRI_DLY(TRI_DLY)) u_qual (
    .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .lvl_hi(lvl_hi), .tri_active(tri_active), .mid_now(mid_now));

  hb_boot_hyst u_boot (
    .clk(clk), .rst_n(rst_n), .boot_hi(boot_hi), .boot_lo(boot_lo),
    .boot_ok(boot_ok));

  assign want = pick_switch(enable, tri_active, lvl_hi, boot_ok);

  hb_dead_adapt #(.DT_MIN(DT_MIN), .DT_MAX(DT_MAX), .DT_INIT(DT_INIT), .DT_W(DT_W)) u_dead (
    .clk(clk), .rst_n(rst_n), .in_dead(in_dead), .finish(finish),
    .diode_sense(diode_sense), .dead_len(dead_len));

  hb_gate_fsm #(.DT_W(DT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .want(want), .dead_len(dead_len),
    .gate_hs(gate_hs), .gate_ls(gate_ls), .in_dead(in_dead), .finish(finish));

  a_r7_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!gate_hs && !gate_ls));
  a_r4_park_off: assert property (@(posedge clk) disable iff (!rst_n)
    tri_active |=> (!gate_hs && !gate_ls));
  a_r6_boot_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_ok |=> !gate_hs);
  a_r1_ls_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_ls) |-> !lvl_hi || $past(!lvl_hi));
  a_r8_reset_off: assert property (@(posedge clk)
    !rst_n |=> (!gate_hs && !gate_ls && !tri_active));
endmodule

// File: tb/hb_gate_sequencer_tb.sv
module hb_gate_sequencer_tb;
  localparam int TRI_DLY = 8;
  localparam int DT_MIN  = 2;
  localparam int DT_MAX  = 7;
  localparam int DT_INIT = 4;

  logic clk = 1'b0;
  logic rst_n, enable, pwm_hi, pwm_lo, boot_hi, boot_lo, diode_sense;
  logic gate_hs, gate_ls, tri_active;
  int   n_checks = 0;
  int   n_errors = 0;

  always #5 clk = ~clk;

  hb_gate_sequencer #(.TRI_DLY(TRI_DLY), .DT_MIN(DT_MIN), .DT_MAX(DT_MAX), .DT_INIT(DT_INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .boot_hi(boot_hi), .boot_lo(boot_lo), .diode_sense(diode_sense),
    .gate_hs(gate_hs), .gate_ls(gate_ls), .tri_active(tri_active));

  // {en, pwm_hi, pwm_lo, boot_hi, boot_lo, exp_hs, exp_ls, exp_tri}
  localparam logic [7:0] VEC [16] = '{
    8'b1010_0010, 8'b1100_0000, 8'b1101_0100, 8'b1100_0100,
    8'b1010_0010, 8'b1100_1000, 8'b1100_0000, 8'b1101_0100,
    8'b0101_0000, 8'b0010_0000, 8'b1010_0010, 8'b1001_0001,
    8'b1110_0001, 8'b1100_0100, 8'b0000_0001, 8'b1010_0010};

  function automatic string vec_tag(input int i);
    case (i)
      1, 2, 3, 5, 6, 7: return "R6";
      8, 9:             return "R7";
      11, 12, 14:       return "R4";
      13:               return "R5";
      default:          return "R1";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // expected dead time after one completed interval
  function automatic int model_step(input int cur, input bit diode);
    if (diode) return (cur - 1 < DT_MIN) ? DT_MIN : cur - 1;
    return (cur + 1 > DT_MAX) ? DT_MAX : cur + 1;
  endfunction

  // drive a new level and count both-off cycles until the target gate turns on
  task automatic measure_gap(input bit go_high, output int gap, output bit overlap);
    gap = 0; overlap = 0;
    pwm_hi = go_high; pwm_lo = !go_high;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (gate_hs && gate_ls) overlap = 1;
      if (!gate_hs && !gate_ls) gap++;
      if (go_high ? gate_hs : gate_ls) break;
    end
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b1; pwm_hi = 1'b0; pwm_lo = 1'b1;
    boot_hi = 1'b0; boot_lo = 1'b0; diode_sense = 1'b0;
    repeat (2) @(negedge clk);
    // R8 reset state
    check("R8 gate_hs in reset", gate_hs, 0);
    check("R8 gate_ls in reset", gate_ls, 0);
    check("R8 tri_active in reset", tri_active, 0);
    rst_n = 1'b1;

    // table walk: steady-state result per vector
    for (int i = 0; i < 16; i++) begin
      {enable, pwm_hi, pwm_lo, boot_hi, boot_lo} = VEC[i][7:3];
      repeat (40) @(negedge clk);
      check($sformatf("%s vec%0d gate_hs", vec_tag(i), i), gate_hs, int'(VEC[i][2]));
      check($sformatf("%s vec%0d gate_ls", vec_tag(i), i), gate_ls, int'(VEC[i][1]));
      check($sformatf("%s vec%0d tri_active", vec_tag(i), i), tri_active, int'(VEC[i][0]));
    end

    // R2 / R3: dead-time gaps track a model across both clamp bounds
    enable = 1'b1; boot_hi = 1'b1; boot_lo = 1'b0; pwm_hi = 1'b0; pwm_lo = 1'b1;
    diode_sense = 1'b0;
    do_reset();
    repeat (20) @(negedge clk);
    begin
      int dt_m;
      int gap;
      bit ov;
      dt_m = model_step(DT_INIT, 1'b0); // first turn-on from idle
      for (int t = 0; t < 10; t++) begin
        diode_sense = (t >= 4);
        measure_gap(t % 2 == 0, gap, ov);
        check($sformatf("R2 gap t%0d", t), gap, dt_m);
        check($sformatf("R2 overlap t%0d", t), int'(ov), 0);
        dt_m = model_step(dt_m, diode_sense);
        repeat (15) @(negedge clk);
      end
      check("R3 dead time at lower clamp", dt_m, DT_MIN);
    end
    diode_sense = 1'b0;

    // R4 / R5: mid qualification, counter restart and exit
    pwm_hi = 1'b0; pwm_lo = 1'b1;
    do_reset();
    repeat (20) @(negedge clk);
    check("R1 low level drives gate_ls", gate_ls, 1);
    for (int rep = 0; rep < 2; rep++) begin
      pwm_hi = 1'b0; pwm_lo = 1'b0;
      repeat (TRI_DLY - 1) @(negedge clk);
      pwm_lo = 1'b1;
      repeat (3) @(negedge clk);
      check($sformatf("R4 short mid ignored tri rep%0d", rep), tri_active, 0);
      check($sformatf("R4 short mid ignored ls rep%0d", rep), gate_ls, 1);
    end
    pwm_hi = 1'b0; pwm_lo = 1'b0;
    repeat (TRI_DLY - 1) @(negedge clk);
    check("R4 tri before delay", tri_active, 0);
    @(negedge clk);
    check("R4 tri at delay", tri_active, 1);
    check("R4 ls still on at delay", gate_ls, 1);
    @(negedge clk);
    check("R4 ls off after park", gate_ls, 0);
    // short valid burst does not exit
    pwm_hi = 1'b1;
    repeat (TRI_DLY - 1) @(negedge clk);
    pwm_hi = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 short valid run keeps park", tri_active, 1);
    pwm_lo = 1'b1;
    repeat (TRI_DLY - 1) @(negedge clk);
    check("R5 tri before exit delay", tri_active, 1);
    @(negedge clk);
    check("R5 tri clears at delay", tri_active, 0);
    repeat (20) @(negedge clk);
    check("R5 switching resumes", gate_ls, 1);

    // R7: enable low takes effect after one edge
    enable = 1'b0;
    @(negedge clk);
    check("R7 gate_ls off after disable", gate_ls, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule